// File: doc/BRIEF.md
# Ethernet Address Lookup Table

This block holds a small table of switch forwarding entries and answers one destination lookup per clock. Software fills the table through a register window. Three data words stage one entry. A write to the table-control register moves the staged words into a chosen row, or pulls a chosen row back into the words. A global control register enables the table, wipes it and carries a VLAN mode flag. One small register per port holds that port's state.

On the lookup side, a request carries a 48-bit destination MAC address and the ingress port number. One cycle later the block returns a port mask. A matching multicast row gives its stored mask. A matching unicast row gives the one-hot form of its stored port number. When no row matches, the frame is flooded to every forwarding port except the one it came from. Port states gate every result. The block drops frames from a port that is not forwarding, and it never sends to such a port. VLAN-aware matching, learning and aging are not part of this block.

Top module: `addr_lookup_table`

## Requirements
- R1: After reset all port states read 0 (disabled), the global control register reads 0, every table row is free and no response is valid.
- R2: The staging words sit at offsets 0x08, 0x0C and 0x10. Word 0x08 holds the row bits from 64 upward, 0x0C holds bits 63:32 and 0x10 holds bits 31:0. Writing table control (offset 0x04) with bit 31 set copies the three words into the row given by the low index bits.
- R3: Writing table control with bit 31 clear loads the indexed row into the three staging words, where it can be read back. The control register then reads back the index with bit 31 clear.
- R4: In global control (offset 0x00), bit 31 enables lookups and bit 2 stores a VLAN mode flag that does not change lookup results. Writing bit 30 makes every row free in that same cycle, and bit 30 always reads back 0.
- R5: Port p has a control register at offset 0x20 + 4*p whose low two bits give its state: 0 disabled, 1 blocking, 2 learning, 3 forwarding.
- R6: A row matches when its type field (bits 61:60) is 1 (address) or 3 (VLAN plus address), its bits 47:0 equal the requested address and the table is enabled. Rows of type 0 or 2 never match. The response (rsp_valid, rsp_hit, rsp_drop, rsp_mask) appears exactly one cycle after lk_valid.
- R7: The address is stored with its first wire byte in bits 47:40, so bit 40 marks a multicast row. A matching multicast row yields the port mask held in bits 66 and up. A matching unicast row yields a one-hot mask of the port number in bits 67:66.
- R8: With no matching row, rsp_hit is 0 and the mask contains every forwarding port except the ingress port.
- R9: A request whose ingress port is not forwarding returns rsp_drop=1 and an all-zero mask.
- R10: Ports that are not in the forwarding state are removed from a matched row's mask.
- R11: When several rows match the same address, the row with the lowest index decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_mac | input | 48 | Destination address; first wire byte in bits 47:40 |
| lk_port | input | PORT_W | Ingress port number |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | A table row matched |
| rsp_drop | output | 1 | Frame dropped because the ingress port is not forwarding |
| rsp_mask | output | NUM_PORTS | Destination port mask |

## Verification
The bench uses the default build: 16 rows and 3 ports, which makes a row 69 bits wide and the top staging word 5 bits. With three ports, one port can be set to blocking while two stay forwarding. That is enough to show flooding that skips the ingress port, masks trimmed by port state, and drops at the ingress at the same time. Sixteen rows leave room to place duplicate addresses at different indices for the priority case, and to place VLAN-only and free rows next to real entries.

// File: rtl/alut_pkg.sv
package alut_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_TCTL  = 8'h04;
  localparam logic [7:0] OFS_WORD0 = 8'h08;
  localparam logic [7:0] OFS_WORD1 = 8'h0C;
  localparam logic [7:0] OFS_WORD2 = 8'h10;
  localparam logic [7:0] OFS_PORT  = 8'h20;

  localparam int CTRL_EN_BIT   = 31;
  localparam int CTRL_CLR_BIT  = 30;
  localparam int CTRL_VLAN_BIT = 2;
  localparam int TCTL_WR_BIT   = 31;

  localparam int TYPE_LO   = 60;
  localparam int MCAST_BIT = 40;
  localparam int PFIELD_LO = 66;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_BLOCK = 2'd1,
    PS_LEARN = 2'd2,
    PS_FWD   = 2'd3
  } port_state_e;

  function automatic logic [7:0] port_ofs(input int p);
    return OFS_PORT + 8'(4 * p);
  endfunction

endpackage

// File: rtl/alut_store.sv
module alut_store
  import alut_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  parameter int ENTRY_W     = 69
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_wr,
  input  logic [7:0]                            reg_addr,
  input  logic [31:0]                           reg_wdata,
  output logic [31:0]                           reg_rdata,
  output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0]   entries,
  output logic                                  tbl_en,
  output logic [NUM_PORTS-1:0][1:0]             port_st,
  output logic                                  clear_evt,
  output logic [NUM_ENTRIES-1:0]                occupied
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int HI_W  = ENTRY_W - 64;

  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] tbl_q;
  logic [HI_W-1:0]  dw0_q;
  logic [31:0]      dw1_q, dw2_q;
  logic [IDX_W-1:0] sel_q;
  logic             en_q, vlan_q;

  logic wr_ctrl, wr_tctl, commit, fetch, sel_ok;
  logic [IDX_W-1:0] tsel;

  assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_tctl   = reg_wr && (reg_addr == OFS_TCTL);
  assign tsel      = reg_wdata[IDX_W-1:0];
  assign sel_ok    = int'(tsel) < NUM_ENTRIES;
  assign clear_evt = wr_ctrl && reg_wdata[CTRL_CLR_BIT];
  assign commit    = wr_tctl && reg_wdata[TCTL_WR_BIT] && sel_ok;
  assign fetch     = wr_tctl && !reg_wdata[TCTL_WR_BIT] && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      dw0_q  <= '0;
      dw1_q  <= '0;
      dw2_q  <= '0;
      sel_q  <= '0;
      en_q   <= 1'b0;
      vlan_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata[CTRL_EN_BIT];
        vlan_q <= reg_wdata[CTRL_VLAN_BIT];
      end
      if (clear_evt) tbl_q <= '0;
      else if (commit) tbl_q[tsel] <= {dw0_q, dw1_q, dw2_q};
      if (wr_tctl) sel_q <= tsel;
      if (fetch) {dw0_q, dw1_q, dw2_q} <= tbl_q[tsel];
      else if (reg_wr && reg_addr == OFS_WORD0) dw0_q <= reg_wdata[HI_W-1:0];
      else if (reg_wr && reg_addr == OFS_WORD1) dw1_q <= reg_wdata;
      else if (reg_wr && reg_addr == OFS_WORD2) dw2_q <= reg_wdata;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PS_OFF;
      else if (reg_wr && reg_addr == port_ofs(p)) st_q <= reg_wdata[1:0];
    end
    assign port_st[p] = st_q;
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_occ
    assign occupied[i] = tbl_q[i][TYPE_LO+1:TYPE_LO] != 2'd0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = en_q;
        reg_rdata[CTRL_VLAN_BIT] = vlan_q;
      end
      OFS_TCTL:  reg_rdata[IDX_W-1:0] = sel_q;
      OFS_WORD0: reg_rdata[HI_W-1:0]  = dw0_q;
      OFS_WORD1: reg_rdata = dw1_q;
      OFS_WORD2: reg_rdata = dw2_q;
      default: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (reg_addr == port_ofs(p)) reg_rdata[1:0] = port_st[p];
      end
    endcase
  end

  assign entries = tbl_q;
  assign tbl_en  = en_q;

endmodule

// File: rtl/alut_match.sv
module alut_match
  import alut_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ENTRY_W     = 69
) (
  input  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries,
  input  logic                                tbl_en,
  input  logic [47:0]                         mac,
  output logic                                hit,
  output logic [ENTRY_W-1:0]                  hit_entry
);
  function automatic logic addr_hit(input logic [ENTRY_W-1:0] e, input logic [47:0] a);
    return e[TYPE_LO] && (e[47:0] == a);
  endfunction

  always_comb begin
    hit       = 1'b0;
    hit_entry = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (tbl_en && addr_hit(entries[i], mac)) begin
        hit       = 1'b1;
        hit_entry = entries[i];
      end
    end
  end

endmodule

// File: rtl/alut_resolve.sv
module alut_resolve
  import alut_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ENTRY_W   = 69,
  parameter int PORT_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [PORT_W-1:0]          lk_port,
  input  logic                       hit,
  input  logic [ENTRY_W-1:0]         hit_entry,
  input  logic [NUM_PORTS-1:0][1:0]  port_st,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_drop,
  output logic [NUM_PORTS-1:0]       rsp_mask,
  output logic [NUM_PORTS-1:0]       fwd_ports
);
  function automatic logic [NUM_PORTS-1:0] dest_of(input logic [ENTRY_W-1:0] e);
    logic [NUM_PORTS-1:0] m;
    m = '0;
    if (e[MCAST_BIT]) m = e[PFIELD_LO +: NUM_PORTS];
    else
      for (int p = 0; p < NUM_PORTS; p++)
        m[p] = (e[PFIELD_LO+1:PFIELD_LO] == 2'(p));
    return m;
  endfunction

  logic [NUM_PORTS-1:0] ingress_1h, flood, dest, next_mask;
  logic                 ingress_fwd;
  logic                 unused_entry_bits;

  assign unused_entry_bits = ^hit_entry;

  always_comb begin
    ingress_fwd = 1'b0;
    ingress_1h  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      fwd_ports[p] = (port_st[p] == PS_FWD);
      if (lk_port == PORT_W'(p)) begin
        ingress_1h[p] = 1'b1;
        ingress_fwd   = (port_st[p] == PS_FWD);
      end
    end
    flood     = fwd_ports & ~ingress_1h;
    dest      = dest_of(hit_entry) & fwd_ports;
    next_mask = !ingress_fwd ? '0 : (hit ? dest : flood);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_drop  <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit;
      rsp_drop  <= lk_valid && !ingress_fwd;
      rsp_mask  <= lk_valid ? next_mask : '0;
    end
  end

endmodule

// File: rtl/addr_lookup_table.sv
module addr_lookup_table
  import alut_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  parameter int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 lk_valid,
  input  logic [47:0]          lk_mac,
  input  logic [PORT_W-1:0]    lk_port,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_drop,
  output logic [NUM_PORTS-1:0] rsp_mask
);
  localparam int ENTRY_W = (PFIELD_LO + NUM_PORTS > 68) ? PFIELD_LO + NUM_PORTS : 68;

  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries;
  logic [NUM_PORTS-1:0][1:0]           port_st;
  logic [NUM_PORTS-1:0]                fwd_ports;
  logic [NUM_ENTRIES-1:0]              occupied;
  logic [ENTRY_W-1:0]                  hit_entry;
  logic                                tbl_en, clear_evt, hit;

  alut_store #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entries(entries),
    .tbl_en(tbl_en), .port_st(port_st), .clear_evt(clear_evt), .occupied(occupied)
  );

  alut_match #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_match (
    .entries(entries), .tbl_en(tbl_en), .mac(lk_mac), .hit(hit), .hit_entry(hit_entry)
  );

  alut_resolve #(.NUM_PORTS(NUM_PORTS), .ENTRY_W(ENTRY_W), .PORT_W(PORT_W)) u_resolve (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_port(lk_port),
    .hit(hit), .hit_entry(hit_entry), .port_st(port_st),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_drop(rsp_drop),
    .rsp_mask(rsp_mask), .fwd_ports(fwd_ports)
  );

endmodule

// File: rtl/alut_checker.sv
module alut_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 3,
  parameter int PORT_W      = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [PORT_W-1:0]      lk_port,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic                   rsp_drop,
  input logic [NUM_PORTS-1:0]   rsp_mask,
  input logic [NUM_PORTS-1:0]   fwd_ports,
  input logic                   clear_evt,
  input logic [NUM_ENTRIES-1:0] occupied
);
  logic [PORT_W-1:0]    ingress_q;
  logic [NUM_PORTS-1:0] fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ingress_q <= '0;
      fwd_q     <= '0;
    end else begin
      ingress_q <= lk_port;
      fwd_q     <= fwd_ports;
    end
  end

  assert_resp_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_clear_frees_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (occupied == '0));
  assert_drop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_drop) |-> (rsp_mask == '0));
  assert_only_fwd_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_mask & ~fwd_q) == '0));
  assert_flood_skips_ingress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (((rsp_mask >> ingress_q) & 1) == 0));

endmodule

bind addr_lookup_table alut_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_port(lk_port),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_drop(rsp_drop),
  .rsp_mask(rsp_mask), .fwd_ports(fwd_ports), .clear_evt(clear_evt),
  .occupied(occupied)
);

// File: tb/sim_addr_lookup_table.sv
`timescale 1ns/1ps
module sim_addr_lookup_table;
  localparam int NE = 16;
  localparam int NP = 3;
  localparam int PW = 2;
  localparam int EW = 69;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          lk_valid = 1'b0;
  logic [47:0]   lk_mac = '0;
  logic [PW-1:0] lk_port = '0;
  logic          rsp_valid, rsp_hit, rsp_drop;
  logic [NP-1:0] rsp_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_lookup_table #(.NUM_ENTRIES(NE), .NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_mac(lk_mac), .lk_port(lk_port), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_drop(rsp_drop), .rsp_mask(rsp_mask)
  );

  // bench model of software-visible state
  logic [EW-1:0] m_tbl [NE];
  logic          m_en;
  logic [1:0]    m_st [NP];

  logic [NP+1:0] exp_q [$];
  string         tag_q [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] ucast(input logic [47:0] a, input int port, input int typ);
    logic [EW-1:0] e = '0;
    e[61:60] = 2'(typ);
    e[47:0]  = a;
    e[67:66] = 2'(port);
    return e;
  endfunction

  function automatic logic [EW-1:0] mcast(input logic [47:0] a, input logic [NP-1:0] m);
    logic [EW-1:0] e = '0;
    e[61:60] = 2'd1;
    e[63:62] = 2'd3;
    e[47:0]  = a;
    e[68:66] = m;
    return e;
  endfunction

  // expected {hit, drop, mask} from the requirements
  function automatic logic [NP+1:0] predict(input logic [47:0] a, input int port);
    logic hit = 1'b0;
    logic [EW-1:0] e = '0;
    logic [NP-1:0] fwd, dest, mask;
    for (int i = 0; i < NE; i++)
      if (!hit && m_en && m_tbl[i][60] && m_tbl[i][47:0] == a) begin
        hit = 1'b1;
        e = m_tbl[i];
      end
    for (int p = 0; p < NP; p++) fwd[p] = (m_st[p] == 2'd3);
    if (!fwd[port]) return {hit, 1'b1, {NP{1'b0}}};
    dest = e[40] ? e[68:66] : NP'(3'b001 << e[67:66]);
    mask = hit ? (dest & fwd) : (fwd & ~NP'(3'b001 << port));
    return {hit, 1'b0, mask};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic put(input int idx, input logic [EW-1:0] e);
    wr(8'h08, 32'(e[68:64]));
    wr(8'h0C, e[63:32]);
    wr(8'h10, e[31:0]);
    wr(8'h04, 32'h8000_0000 | 32'(idx));
    m_tbl[idx] = e;
  endtask

  task automatic set_port(input int p, input logic [1:0] s);
    wr(8'h20 + 8'(4 * p), 32'(s));
    m_st[p] = s;
  endtask

  task automatic lookup(input logic [47:0] a, input int port, input string req);
    @(negedge clk);
    exp_q.push_back(predict(a, port));
    tag_q.push_back(req);
    lk_valid = 1'b1; lk_mac = a; lk_port = PW'(port);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual unexpected response expected none");
      end else begin
        logic [NP+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'({rsp_hit, rsp_drop, rsp_mask}), 64'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_M = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MAC_B = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] MAC_C = 48'h02_C0_C0_C0_C0_C0;
  localparam logic [47:0] MAC_D = 48'h02_D0_00_00_00_0D;
  localparam logic [47:0] MAC_E = 48'h02_E0_00_00_00_0E;
  localparam logic [47:0] MAC_U = 48'h02_99_99_99_99_99;

  initial begin
    for (int i = 0; i < NE; i++) m_tbl[i] = '0;
    for (int p = 0; p < NP; p++) m_st[p] = 2'd0;
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h24, 32'h0, "R1 port1 state");
    lookup(MAC_U, 0, "R1 disabled port drops");

    // R5 port states
    set_port(0, 2'd3); set_port(1, 2'd3); set_port(2, 2'd3);
    rd(8'h24, 32'h3, "R5 port1 readback");
    rd(8'h28, 32'h3, "R5 port2 readback");

    // R4 enable with vlan flag
    wr(8'h00, 32'h8000_0004);
    m_en = 1'b1;
    rd(8'h00, 32'h8000_0004, "R4 ctrl readback");

    // R2 table contents
    put(2, ucast(MAC_A, 1, 1));
    put(3, ucast(MAC_B, 2, 2));
    put(5, mcast(MAC_M, 3'b101));
    put(7, ucast(MAC_C, 2, 1));
    put(9, ucast(MAC_C, 0, 1));
    put(10, ucast(MAC_D, 1, 0));
    put(11, ucast(MAC_E, 0, 3));

    // R3 load row 5 back after clobbering staging words
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h1234_5678);
    wr(8'h04, 32'h0000_0005);
    rd(8'h08, 32'(m_tbl[5][68:64]), "R3 word0 of row 5");
    rd(8'h0C, m_tbl[5][63:32], "R3 word1 of row 5");
    rd(8'h10, m_tbl[5][31:0], "R3 word2 of row 5");
    rd(8'h04, 32'h0000_0005, "R3 tctl readback");

    // lookups with all ports forwarding
    lookup(MAC_A, 0, "R7 unicast port1");
    lookup(MAC_M, 1, "R7 multicast mask");
    lookup(MAC_B, 0, "R6 vlan row ignored flood");
    lookup(MAC_C, 1, "R11 lowest index wins");
    lookup(MAC_D, 0, "R6 free row ignored");
    lookup(MAC_E, 2, "R6 type3 matches");
    lookup(MAC_U, 2, "R8 flood skips ingress");

    // port 2 blocking
    set_port(2, 2'd1);
    lookup(MAC_A, 2, "R9 ingress blocking drop");
    lookup(MAC_M, 0, "R10 blocked dest removed");
    lookup(MAC_C, 0, "R10 unicast to blocked port");
    lookup(MAC_U, 0, "R8 flood only forwarding");

    // disabled table
    wr(8'h00, 32'h0);
    m_en = 1'b0;
    lookup(MAC_A, 0, "R6 disabled table no match");

    // R4 clear
    wr(8'h00, 32'hC000_0000);
    m_en = 1'b1;
    for (int i = 0; i < NE; i++) m_tbl[i] = '0;
    rd(8'h00, 32'h8000_0000, "R4 clear bit self clears");
    lookup(MAC_A, 0, "R4 cleared table misses");
    wr(8'h04, 32'h0000_0002);
    rd(8'h0C, 32'h0, "R4 cleared row word1");
    rd(8'h10, 32'h0, "R4 cleared row word2");

    repeat (3) @(negedge clk);
    chk("R6 all responses seen", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule